// File: doc/BRIEF.md
# Transition-Frequency Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a single global record of the most recent committed outcomes, and it keeps one frequency table for each branch kind. Each table has one row for every history value and two counter columns. To make a prediction, the block forms the two histories that could follow the current one: the current history shifted left with a 0 appended, and the same shift with a 1 appended. The bit that leaves the history on that shift picks the column. The block reads both candidate rows in that column, from the table chosen by the branch kind. It predicts the appended bit of the candidate with the larger count, and it predicts taken when the two counts are equal.

When a branch resolves, the commit port supplies the branch kind and the real outcome. The block then increments the counter of the history that actually occurred, in the column chosen by the outgoing bit, and the counter stops at its all-ones ceiling. If that counter and its competitor in the same column both sit at the ceiling after the update, both are cleared, so old statistics do not dominate. The same commit shifts the outcome into the global history. Prediction is combinational on the current state. A prediction made in the same cycle as a commit therefore sees the state from before that commit.

Top module: `trans_freq_predictor`

## Requirements
- R1: While reset is asserted and directly after reset, the history and every counter are zero, so every branch kind is predicted taken (pred_taken = 1).
- R2: With history h, the block reads column h[HIST_W-1] at rows {h[HIST_W-2:0],0} and {h[HIST_W-2:0],1} in the table selected by pred_type. It predicts 1 when the second count is larger and 0 when the first is larger.
- R3: When the two candidate counts are equal, the prediction is taken (1).
- R4: Each branch kind (pred_type/commit_type value 0..3) owns a separate table. A commit of one kind never changes the prediction counts of another kind.
- R5: A commit with commit_valid = 1 increments the counter at row {h[HIST_W-2:0],commit_taken}, column h[HIST_W-1], in the table selected by commit_type.
- R6: A counter at its maximum (all ones, 2^CNT_W-1) is not incremented further and does not wrap.
- R7: If after the increment the updated counter and the competing row (the other appended bit, same column, same table) both equal the maximum, both are written to zero.
- R8: A commit shifts commit_taken into bit 0 of the history. With commit_valid = 0 the history and the tables are unchanged, whatever the other commit inputs are.
- R9: A prediction made in the same cycle as a commit reflects the state before that commit, and the new state is visible from the following cycle.
- R10: HIST_W of at least 2, CNT_W of at least 1 and TYPE_W of at least 1 are enforced when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_type | input | TYPE_W | Branch kind of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| commit_valid | input | 1 | A resolved branch is presented this cycle |
| commit_type | input | TYPE_W | Branch kind of the resolved branch |
| commit_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The checker watches the history shift and hold, the stability of a prediction while no commit arrives and the branch kind is unchanged, and the counter update rules on every cycle. Those update rules are the increment, the stop at the ceiling and the paired clear, and the checker compares the update logic against the values the tables supply. Which row and column a commit lands in, the separation between branch kinds, the preference for taken on a tie, and the fact that a clear really empties both entries can only be shown by the bench. It does this by steering the history through chosen values and reading the resulting predictions.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
   // How a commit changes the winning / losing counter pair
   typedef enum logic {
      UPD_WRITE = 1'b0,   // write the (saturated) increment to the winning row
      UPD_CLEAR = 1'b1    // both rows of the pair reached the ceiling: zero them
   } upd_kind_e;
endpackage

// File: rtl/tfp_hist.sv
module tfp_hist #(
   parameter int unsigned HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist_o
);
   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hist_q <= '0;
      else if (shift_en)
         hist_q <= {hist_q[HIST_W-2:0], shift_bit};
   end

   assign hist_o = hist_q;
endmodule

// File: rtl/tfp_freq_bank.sv
module tfp_freq_bank #(
   parameter int unsigned HIST_W = 8,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned TYPE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   // prediction read port: two rows, one column
   input  logic [TYPE_W-1:0]    pa_type,
   input  logic [HIST_W-1:0]    pa_row0,
   input  logic [HIST_W-1:0]    pa_row1,
   input  logic                 pa_col,
   output logic [CNT_W-1:0]     pa_cnt0,
   output logic [CNT_W-1:0]     pa_cnt1,
   // commit read port: winning and losing rows, one column
   input  logic [TYPE_W-1:0]    cm_type,
   input  logic [HIST_W-1:0]    cm_win_row,
   input  logic [HIST_W-1:0]    cm_lose_row,
   input  logic                 cm_col,
   output logic [CNT_W-1:0]     cm_win_cnt,
   output logic [CNT_W-1:0]     cm_lose_cnt,
   // write port, shares the commit addresses
   input  logic                 wr_en,
   input  tfp_pkg::upd_kind_e   wr_kind,
   input  logic [CNT_W-1:0]     wr_win_val
);
   localparam int unsigned ROWS   = 1 << HIST_W;
   localparam int unsigned NTYPES = 1 << TYPE_W;

   logic [CNT_W-1:0] pa0_t [NTYPES];
   logic [CNT_W-1:0] pa1_t [NTYPES];
   logic [CNT_W-1:0] cw_t  [NTYPES];
   logic [CNT_W-1:0] cl_t  [NTYPES];

   for (genvar g = 0; g < NTYPES; g++) begin : g_table
      logic [CNT_W-1:0] mem [ROWS][2];
      logic             sel_wr;

      assign sel_wr = wr_en && (cm_type == TYPE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
               mem[r][0] <= '0;
               mem[r][1] <= '0;
            end
         end else if (sel_wr) begin
            if (wr_kind == tfp_pkg::UPD_CLEAR) begin
               mem[cm_win_row][cm_col]  <= '0;
               mem[cm_lose_row][cm_col] <= '0;
            end else begin
               mem[cm_win_row][cm_col]  <= wr_win_val;
            end
         end
      end

      assign pa0_t[g] = mem[pa_row0][pa_col];
      assign pa1_t[g] = mem[pa_row1][pa_col];
      assign cw_t[g]  = mem[cm_win_row][cm_col];
      assign cl_t[g]  = mem[cm_lose_row][cm_col];
   end

   assign pa_cnt0     = pa0_t[pa_type];
   assign pa_cnt1     = pa1_t[pa_type];
   assign cm_win_cnt  = cw_t[cm_type];
   assign cm_lose_cnt = cl_t[cm_type];
endmodule

// File: rtl/tfp_update.sv
module tfp_update #(
   parameter int unsigned CNT_W = 4
) (
   input  logic               [CNT_W-1:0] win_cnt,
   input  logic               [CNT_W-1:0] lose_cnt,
   output logic               [CNT_W-1:0] win_val,
   output tfp_pkg::upd_kind_e             kind
);
   localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

   always_comb begin
      win_val = (win_cnt == CEIL) ? win_cnt : win_cnt + 1'b1;
      kind    = ((win_val == CEIL) && (lose_cnt == CEIL)) ? tfp_pkg::UPD_CLEAR
                                                          : tfp_pkg::UPD_WRITE;
   end
endmodule

// File: rtl/tfp_vote.sv
module tfp_vote #(
   parameter int unsigned CNT_W     = 4,
   parameter bit          TIE_TAKEN = 1'b1
) (
   input  logic [CNT_W-1:0] cnt_nt,
   input  logic [CNT_W-1:0] cnt_tk,
   output logic             taken
);
   if (TIE_TAKEN) begin : g_tie_taken
      assign taken = (cnt_tk >= cnt_nt);
   end else begin : g_tie_not_taken
      assign taken = (cnt_tk > cnt_nt);
   end
endmodule

// File: rtl/trans_freq_predictor.sv
module trans_freq_predictor #(
   parameter int unsigned HIST_W    = 8,
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned TYPE_W    = 2,
   parameter bit          TIE_TAKEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TYPE_W-1:0] pred_type,
   output logic              pred_taken,
   input  logic              commit_valid,
   input  logic [TYPE_W-1:0] commit_type,
   input  logic              commit_taken
);
   // R10: parameter legality
   if (HIST_W < 2) begin : g_bad_hist
      $error("trans_freq_predictor: HIST_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("trans_freq_predictor: CNT_W must be at least 1");
   end
   if (TYPE_W < 1) begin : g_bad_type
      $error("trans_freq_predictor: TYPE_W must be at least 1");
   end

   logic [HIST_W-1:0]  hist_q;
   logic [HIST_W-1:0]  pa_row0, pa_row1;
   logic               xcol;
   logic [CNT_W-1:0]   pa_cnt0, pa_cnt1;
   logic [HIST_W-1:0]  cm_win_row, cm_lose_row;
   logic [CNT_W-1:0]   cm_win_cnt, cm_lose_cnt;
   logic [CNT_W-1:0]   upd_win_val;
   tfp_pkg::upd_kind_e upd_kind;

   // outgoing history bit names the column for both ports
   assign xcol        = hist_q[HIST_W-1];
   assign pa_row0     = {hist_q[HIST_W-2:0], 1'b0};
   assign pa_row1     = {hist_q[HIST_W-2:0], 1'b1};
   assign cm_win_row  = {hist_q[HIST_W-2:0], commit_taken};
   assign cm_lose_row = {hist_q[HIST_W-2:0], ~commit_taken};

   tfp_hist #(.HIST_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (commit_valid),
      .shift_bit (commit_taken),
      .hist_o    (hist_q)
   );

   tfp_freq_bank #(.HIST_W(HIST_W), .CNT_W(CNT_W), .TYPE_W(TYPE_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .pa_type     (pred_type),
      .pa_row0     (pa_row0),
      .pa_row1     (pa_row1),
      .pa_col      (xcol),
      .pa_cnt0     (pa_cnt0),
      .pa_cnt1     (pa_cnt1),
      .cm_type     (commit_type),
      .cm_win_row  (cm_win_row),
      .cm_lose_row (cm_lose_row),
      .cm_col      (xcol),
      .cm_win_cnt  (cm_win_cnt),
      .cm_lose_cnt (cm_lose_cnt),
      .wr_en       (commit_valid),
      .wr_kind     (upd_kind),
      .wr_win_val  (upd_win_val)
   );

   tfp_update #(.CNT_W(CNT_W)) u_update (
      .win_cnt  (cm_win_cnt),
      .lose_cnt (cm_lose_cnt),
      .win_val  (upd_win_val),
      .kind     (upd_kind)
   );

   tfp_vote #(.CNT_W(CNT_W), .TIE_TAKEN(TIE_TAKEN)) u_vote (
      .cnt_nt (pa_cnt0),
      .cnt_tk (pa_cnt1),
      .taken  (pred_taken)
   );
endmodule

// File: rtl/trans_freq_predictor_chk.sv
module trans_freq_predictor_chk #(
   parameter int unsigned HIST_W = 8,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned TYPE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [TYPE_W-1:0]  pred_type,
   input logic               pred_taken,
   input logic               commit_valid,
   input logic               commit_taken,
   input logic [HIST_W-1:0]  hist_q,
   input logic [CNT_W-1:0]   cm_win_cnt,
   input logic [CNT_W-1:0]   cm_lose_cnt,
   input logic [CNT_W-1:0]   upd_win_val,
   input tfp_pkg::upd_kind_e upd_kind
);
   localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

   // R8
   hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(commit_taken)});

   // R8
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_valid |=> $stable(hist_q));

   // R8
   pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_valid |=> (pred_type != $past(pred_type)) || (pred_taken == $past(pred_taken)));

   // R5
   incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && cm_win_cnt != CEIL) |-> upd_win_val == cm_win_cnt + 1'b1);

   // R6
   ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && cm_win_cnt == CEIL) |-> upd_win_val == CEIL);

   // R7
   pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && upd_kind == tfp_pkg::UPD_CLEAR) |-> cm_lose_cnt == CEIL);
endmodule

bind trans_freq_predictor trans_freq_predictor_chk #(
   .HIST_W (HIST_W),
   .CNT_W  (CNT_W),
   .TYPE_W (TYPE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pred_type    (pred_type),
   .pred_taken   (pred_taken),
   .commit_valid (commit_valid),
   .commit_taken (commit_taken),
   .hist_q       (hist_q),
   .cm_win_cnt   (cm_win_cnt),
   .cm_lose_cnt  (cm_lose_cnt),
   .upd_win_val  (upd_win_val),
   .upd_kind     (upd_kind)
);

// File: tb/test_trans_freq_predictor.sv
module test_trans_freq_predictor;
   localparam int unsigned HW = 4;   // 16 rows per table
   localparam int unsigned CW = 2;   // ceiling 3
   localparam int unsigned TW = 2;
   localparam int NSTEP = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] pred_type = '0;
   logic          pred_taken;
   logic          commit_valid = 1'b0;
   logic [TW-1:0] commit_type = '0;
   logic          commit_taken = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   trans_freq_predictor #(.HIST_W(HW), .CNT_W(CW), .TYPE_W(TW)) i_trans_freq_predictor (
      .clk          (clk),
      .rst_n        (rst_n),
      .pred_type    (pred_type),
      .pred_taken   (pred_taken),
      .commit_valid (commit_valid),
      .commit_taken (commit_taken),
      .commit_type  (commit_type)
   );

   // {commit kind, commit outcome, predict kind, expected prediction}
   // hand-derived from the requirements; history walk noted per row
   localparam logic [5:0] VEC [NSTEP] = '{
      {2'd0,1'b0,2'd0,1'b0},  //  1 h=0000 t0[0]c0=1          R5 R2
      {2'd0,1'b0,2'd1,1'b1},  //  2 t0[0]c0=2, kind1 empty    R4 R3
      {2'd0,1'b0,2'd0,1'b0},  //  3 t0[0]c0=3 (ceiling)       R5
      {2'd0,1'b0,2'd0,1'b0},  //  4 stays 3, no wrap          R6
      {2'd0,1'b1,2'd0,1'b1},  //  5 t0[1]c0=1, h=0001         R8 R3
      {2'd2,1'b0,2'd2,1'b1},  //  6 h=0010                    R4
      {2'd2,1'b0,2'd0,1'b1},  //  7 h=0100
      {2'd2,1'b0,2'd2,1'b1},  //  8 h=1000
      {2'd2,1'b0,2'd0,1'b0},  //  9 h=0000 t0: 3 vs 1         R2
      {2'd0,1'b1,2'd3,1'b1},  // 10 t0[1]c0=2, h=0001
      {2'd2,1'b0,2'd2,1'b0},  // 11 h=0010 t2[4]c0=1 vs 0     R2
      {2'd2,1'b0,2'd2,1'b0},  // 12 h=0100
      {2'd2,1'b0,2'd2,1'b0},  // 13 h=1000 uses column 1      R2
      {2'd2,1'b0,2'd0,1'b0},  // 14 h=0000 t0: 3 vs 2
      {2'd0,1'b1,2'd0,1'b1},  // 15 both reach 3 -> cleared   R7
      {2'd2,1'b0,2'd2,1'b0},  // 16 h=0010
      {2'd2,1'b0,2'd1,1'b1},  // 17 h=0100
      {2'd2,1'b0,2'd2,1'b0},  // 18 h=1000
      {2'd2,1'b0,2'd0,1'b1},  // 19 h=0000 t0 pair now 0/0   R7
      {2'd0,1'b0,2'd0,1'b0}   // 20 counting restarts at 1    R7
   };

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: pred_taken=%0b expected=%0b", req, got, exp);
      end
   endtask

   task automatic commit_then_predict(input logic [TW-1:0] ct, input logic co,
                                      input logic [TW-1:0] pt, input logic exp,
                                      input string req);
      @(negedge clk);
      commit_type  = ct;
      commit_taken = co;
      commit_valid = 1'b1;
      @(negedge clk);
      commit_valid = 1'b0;
      pred_type    = pt;
      #1;
      check(req, pred_taken, exp);
   endtask

   initial begin
      // R1: reset state, every kind predicts taken
      for (int k = 0; k < 4; k++) begin
         pred_type = TW'(k);
         #1;
         check("R1", pred_taken, 1'b1);
         #2;
      end
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NSTEP; i++) begin
         commit_then_predict(VEC[i][5:4], VEC[i][3], VEC[i][2:1], VEC[i][0],
                             $sformatf("R2/R5/R6/R7 step %0d", i + 1));
      end
      // history 0000, t0[0]c0 = 1

      // R9: same-cycle prediction sees the old state, new state next cycle
      @(negedge clk);
      commit_type  = 2'd0;
      commit_taken = 1'b1;
      commit_valid = 1'b1;
      pred_type    = 2'd0;
      #1;
      check("R9 before edge", pred_taken, 1'b0);
      @(negedge clk);
      commit_valid = 1'b0;
      #1;
      check("R9 after edge", pred_taken, 1'b1);   // h=0001, rows 0010/0011 empty

      // R8: inputs move while commit_valid is low; nothing may change
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         commit_type  = TW'(c);
         commit_taken = 1'b1;
      end
      // real commit kind2 not-taken from h=0001 -> h=0010, t2[4]c0=3 vs t2[5]c0=0
      commit_then_predict(2'd2, 1'b0, 2'd2, 1'b0, "R8 ignored commit inputs");

      // R1: reset in the middle of a run clears history and tables
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      pred_type = 2'd2;
      #1;
      check("R1 kind2 after reset", pred_taken, 1'b1);
      pred_type = 2'd0;
      #1;
      check("R1 kind0 after reset", pred_taken, 1'b1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule